// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits on the host side of a byte-wide parallel flash. It takes one request at a time on a valid/ready interface: program one byte, erase the whole array, or erase a set of sectors given as a bit mask. It then produces the unlock and command writes that the flash expects. Each write or read is a bus cycle with three parts. First comes a setup phase, in which address and data are driven but the strobes are idle. Next comes a strobe phase, in which chip enable goes low together with write enable (for a write) or output enable (for a read). Last comes a hold phase, in which the strobes are idle again. The length of each phase is a parameter.

After the command writes, the sequencer reads status from the flash until the operation is complete. On a program, status is read at the byte being programmed. On a chip erase, it is read at the request address. On a sector erase, it is read at the base of the lowest selected sector. Completion is judged from data bit 7. Bit 5 marks a device-side time limit. When bit 5 is set, status is read one more time. If the operation is still not complete, the flash is sent back to read mode with a three-write reset sequence and a failure is reported. If polling runs out of its cycle budget, a host timeout is reported. Every request ends in a one-cycle response that carries a result code.

Top module: `flash_cmd_seq`

## Requirements
- R1: Request op 0 (program) issues four writes, in this order: AAh@5555h, 55h@2AAAh, A0h@5555h, then `req_data`@`req_addr`. Command addresses have every bit above bit 14 at zero.
- R2: Request op 1 (chip erase) issues six writes, in this order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h.
- R3: Request op 2 (sector erase) issues the same first five writes as R2. It then writes 30h once for every set bit i of `req_sect_mask`, at address i << (ADDR_W − log2 NUM_SECT), in ascending order of i. The writes follow each other back to back.
- R4: Op 3, or op 2 with an all-zero mask, gets response code 3 in the cycle after acceptance and produces no bus cycle.
- R5: In every bus cycle, address and data stay stable from setup to hold. Chip enable is low for exactly PULSE_CYC clocks, together with write enable (for a write, with `fl_dq_oe` high) or output enable (for a read, with `fl_dq_oe` low). Write enable and output enable are never low at the same time.
- R6: After a program, status is read at `req_addr`. The operation completes with code 0 on the first read whose bit 7 equals bit 7 of `req_data`.
- R7: After an erase, status is read at `req_addr` (chip erase) or at the base of the lowest selected sector (sector erase). The operation completes with code 0 on the first read with bit 7 = 1.
- R8: A read that is not complete but has bit 5 = 1 is followed by exactly one more status read. If that read is complete, the response is code 0.
- R9: If that extra read is also not complete, the block writes AAh@5555h, 55h@2AAAh, F0h@5555h and then responds with code 1.
- R10: After POLL_LIMIT status reads that are neither complete nor carry bit 5, the response is code 2 and no reset writes follow.
- R11: `req_ready` is high only while idle. A request held valid during an operation is not taken. `rsp_valid` lasts one cycle and is followed by `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_op | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 invalid |
| req_addr | input | ADDR_W | Byte address for program, status address for chip erase |
| req_data | input | DATA_W | Byte to program |
| req_sect_mask | input | NUM_SECT | Sectors to erase, bit i selects sector i |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_code | output | 2 | 0 done, 1 device failure, 2 host timeout, 3 rejected |
| fl_addr | output | ADDR_W | Flash address |
| fl_dout | output | DATA_W | Data driven to the flash |
| fl_dq_oe | output | 1 | Data driver enable during write cycles |
| fl_din | input | DATA_W | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest cases to reach are the narrow outcomes of the bit 5 path. These are a recheck that rescues the operation, a recheck that leads to the reset writes, and a bit 5 that arrives on the very last read the poll budget allows. A real part only produces these when it fails. The bench therefore replaces the flash with a status model that counts completed reads. This model can be told to stay busy for B reads and then complete, raise bit 5 and stay stuck, raise bit 5 once and then complete, or never finish. Sweeping B from zero to past POLL_LIMIT reaches every boundary between the done, failure and timeout outcomes. The expected read and write counts follow directly from B.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_CHIP = 2'd1,
      OP_SECT = 2'd2,
      OP_BAD  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      RC_DONE    = 2'd0,
      RC_DEVFAIL = 2'd1,
      RC_HOSTTMO = 2'd2,
      RC_REJECT  = 2'd3
   } rc_e;

   typedef struct packed {
      logic [15:0] addr;
      logic [7:0]  data;
   } cmd_word_t;

   localparam logic [15:0] KEY_ADDR_A = 16'h5555;
   localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

   // Generic step table; the top overrides the target-address steps.
   function automatic cmd_word_t seq_word(input op_e op, input logic rst_seq,
                                          input logic [2:0] step);
      cmd_word_t w;
      case (step)
         3'd0:    w = '{addr: KEY_ADDR_A, data: 8'hAA};
         3'd1:    w = '{addr: KEY_ADDR_B, data: 8'h55};
         3'd2:    w = '{addr: KEY_ADDR_A,
                        data: rst_seq ? 8'hF0 : ((op == OP_PROG) ? 8'hA0 : 8'h80)};
         3'd3:    w = '{addr: KEY_ADDR_A, data: 8'hAA};
         3'd4:    w = '{addr: KEY_ADDR_B, data: 8'h55};
         default: w = '{addr: KEY_ADDR_A, data: 8'h10};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3,
   parameter int HOLD_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_dout,
   output logic              fl_dq_oe,
   input  logic [DATA_W-1:0] fl_din,
   output logic              fl_ce_n,
   output logic              fl_we_n,
   output logic              fl_oe_n
);
   localparam int MAXC  = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
   localparam int CNT_W = $clog2(MAXC + 1);

   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;

   phase_e            ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              rd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         rd_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         rdata  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph_q)
            PH_IDLE: if (start) begin
               ph_q   <= PH_SETUP;
               cnt_q  <= '0;
               rd_q   <= is_rd;
               addr_q <= addr;
               data_q <= is_rd ? '0 : wdata;
            end
            PH_SETUP: if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
               ph_q  <= PH_PULSE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_PULSE: if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
               ph_q  <= PH_HOLD;
               cnt_q <= '0;
               if (rd_q) rdata <= fl_din;
            end else cnt_q <= cnt_q + 1'b1;
            default: if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
               ph_q  <= PH_IDLE;
               cnt_q <= '0;
               done  <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
         endcase
      end
   end

   assign fl_addr  = addr_q;
   assign fl_dout  = data_q;
   assign fl_dq_oe = (ph_q != PH_IDLE) && !rd_q;
   assign fl_ce_n  = (ph_q != PH_PULSE);
   assign fl_we_n  = !((ph_q == PH_PULSE) && !rd_q);
   assign fl_oe_n  = !((ph_q == PH_PULSE) && rd_q);

endmodule

// File: rtl/flash_sect_scan.sv
module flash_sect_scan #(
   parameter int N = 8,
   parameter int W = $clog2(N)
) (
   input  logic [N-1:0] mask,
   output logic [W-1:0] idx,
   output logic [N-1:0] onehot,
   output logic         any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign onehot[g]  = mask[g] & ~seen[g];
      assign seen[g+1]  = seen[g] | mask[g];
   end
   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++)
         if (onehot[i]) idx = idx | W'(i);
   end

endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] rd,
   input  logic              exp_b7,
   input  logic              is_prog,
   output logic              complete,
   output logic              limit_hit
);
   assign complete  = is_prog ? (rd[7] == exp_b7) : rd[7];
   assign limit_hit = rd[5];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W       = 17,
   parameter int DATA_W       = 8,
   parameter int NUM_SECT     = 8,
   parameter int SETUP_CYC    = 2,
   parameter int PULSE_CYC    = 3,
   parameter int HOLD_CYC     = 1,
   parameter int POLL_LIMIT   = 1000,
   parameter int SECT_GAP_CYC = 4000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [1:0]          req_op,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   input  logic [NUM_SECT-1:0] req_sect_mask,
   output logic                rsp_valid,
   output logic [1:0]          rsp_code,
   output logic [ADDR_W-1:0]   fl_addr,
   output logic [DATA_W-1:0]   fl_dout,
   output logic                fl_dq_oe,
   input  logic [DATA_W-1:0]   fl_din,
   output logic                fl_ce_n,
   output logic                fl_we_n,
   output logic                fl_oe_n
);
   localparam int SECT_W     = $clog2(NUM_SECT);
   localparam int SECT_SHIFT = ADDR_W - SECT_W;
   localparam int POLL_W     = $clog2(POLL_LIMIT + 1);
   localparam int BUS_LEN    = SETUP_CYC + PULSE_CYC + HOLD_CYC + 1;

   if (ADDR_W < 15)                          begin : g_bad_aw   $error("ADDR_W too small for command addresses"); end
   if (DATA_W < 8)                           begin : g_bad_dw   $error("DATA_W must be at least 8"); end
   if (NUM_SECT < 2 || (1 << SECT_W) != NUM_SECT) begin : g_bad_ns $error("NUM_SECT must be a power of two >= 2"); end
   if (SETUP_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_ph $error("phase lengths must be >= 1"); end
   if (POLL_LIMIT < 1)                       begin : g_bad_pl   $error("POLL_LIMIT must be >= 1"); end
   if (BUS_LEN >= SECT_GAP_CYC)              begin : g_bad_gap  $error("bus cycle exceeds sector queue window"); end

   typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_POLL, ST_RECHK, ST_RST, ST_RESP} st_e;

   st_e                 st_q;
   op_e                 op_q;
   rc_e                 code_q;
   logic [ADDR_W-1:0]   addr_q, poll_addr_q;
   logic [DATA_W-1:0]   data_q;
   logic [NUM_SECT-1:0] mask_q;
   logic [2:0]          step_q;
   logic [POLL_W-1:0]   polls_q;
   logic                go_q;

   logic [SECT_W-1:0]   idx_req, idx_rem;
   logic [NUM_SECT-1:0] oh_req, oh_rem;
   logic                any_req, any_rem;
   logic                bus_done, bus_rd, complete, limit_hit;
   logic [DATA_W-1:0]   bus_rdata, bus_data;
   logic [ADDR_W-1:0]   bus_addr;
   cmd_word_t           w;
   op_e                 req_op_e;

   assign req_op_e = op_e'(req_op);

   flash_sect_scan #(.N(NUM_SECT), .W(SECT_W)) u_scan_req (
      .mask(req_sect_mask), .idx(idx_req), .onehot(oh_req), .any(any_req));
   flash_sect_scan #(.N(NUM_SECT), .W(SECT_W)) u_scan_rem (
      .mask(mask_q), .idx(idx_rem), .onehot(oh_rem), .any(any_rem));

   function automatic logic [ADDR_W-1:0] sect_base(input logic [SECT_W-1:0] i);
      return ADDR_W'(i) << SECT_SHIFT;
   endfunction

   always_comb begin
      w        = seq_word(op_q, st_q == ST_RST, step_q);
      bus_addr = ADDR_W'(w.addr);
      bus_data = DATA_W'(w.data);
      bus_rd   = 1'b0;
      case (st_q)
         ST_CMD: begin
            if (op_q == OP_PROG && step_q == 3'd3) begin
               bus_addr = addr_q;
               bus_data = data_q;
            end else if (op_q == OP_SECT && step_q == 3'd5) begin
               bus_addr = sect_base(idx_rem);
               bus_data = DATA_W'(8'h30);
            end
         end
         ST_POLL, ST_RECHK: begin
            bus_addr = poll_addr_q;
            bus_data = '0;
            bus_rd   = 1'b1;
         end
         default: ;
      endcase
   end

   flash_bus_cycle #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .start(go_q), .is_rd(bus_rd),
      .addr(bus_addr), .wdata(bus_data), .done(bus_done), .rdata(bus_rdata),
      .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dq_oe(fl_dq_oe), .fl_din(fl_din),
      .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

   flash_poll_eval #(.DATA_W(DATA_W)) u_eval (
      .rd(bus_rdata), .exp_b7(data_q[7]), .is_prog(op_q == OP_PROG),
      .complete(complete), .limit_hit(limit_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         op_q        <= OP_PROG;
         code_q      <= RC_DONE;
         addr_q      <= '0;
         poll_addr_q <= '0;
         data_q      <= '0;
         mask_q      <= '0;
         step_q      <= '0;
         polls_q     <= '0;
         go_q        <= 1'b0;
      end else begin
         go_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (req_valid) begin
               op_q        <= req_op_e;
               addr_q      <= req_addr;
               data_q      <= req_data;
               mask_q      <= req_sect_mask;
               poll_addr_q <= (req_op_e == OP_SECT) ? sect_base(idx_req) : req_addr;
               step_q      <= '0;
               polls_q     <= '0;
               if (req_op_e == OP_BAD || (req_op_e == OP_SECT && !any_req)) begin
                  code_q <= RC_REJECT;
                  st_q   <= ST_RESP;
               end else begin
                  st_q <= ST_CMD;
                  go_q <= 1'b1;
               end
            end
            ST_CMD: if (bus_done) begin
               go_q <= 1'b1;
               if (op_q == OP_SECT && step_q == 3'd5) begin
                  mask_q <= mask_q & ~oh_rem;
                  if ((mask_q & ~oh_rem) == '0) st_q <= ST_POLL;
               end else if ((op_q == OP_PROG && step_q == 3'd3) ||
                            (op_q == OP_CHIP && step_q == 3'd5)) begin
                  st_q <= ST_POLL;
               end else begin
                  step_q <= step_q + 3'd1;
               end
            end
            ST_POLL: if (bus_done) begin
               polls_q <= polls_q + 1'b1;
               if (complete) begin
                  code_q <= RC_DONE;
                  st_q   <= ST_RESP;
               end else if (limit_hit) begin
                  st_q <= ST_RECHK;
                  go_q <= 1'b1;
               end else if (polls_q == POLL_W'(POLL_LIMIT - 1)) begin
                  code_q <= RC_HOSTTMO;
                  st_q   <= ST_RESP;
               end else begin
                  go_q <= 1'b1;
               end
            end
            ST_RECHK: if (bus_done) begin
               if (complete) begin
                  code_q <= RC_DONE;
                  st_q   <= ST_RESP;
               end else begin
                  step_q <= '0;
                  st_q   <= ST_RST;
                  go_q   <= 1'b1;
               end
            end
            ST_RST: if (bus_done) begin
               if (step_q == 3'd2) begin
                  code_q <= RC_DEVFAIL;
                  st_q   <= ST_RESP;
               end else begin
                  step_q <= step_q + 3'd1;
                  go_q   <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign rsp_valid = (st_q == ST_RESP);
   assign rsp_code  = code_q;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int PULSE_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_op,
   input logic              rsp_valid,
   input logic [1:0]        rsp_code,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [DATA_W-1:0] fl_dout,
   input logic              fl_dq_oe,
   input logic              fl_ce_n,
   input logic              fl_we_n,
   input logic              fl_oe_n
);
   logic        strobe;
   logic [15:0] lo_cnt;

   assign strobe = !fl_we_n || !fl_oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lo_cnt <= '0;
      else if (strobe) lo_cnt <= lo_cnt + 16'd1;
      else             lo_cnt <= '0;
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_oe_n)); // R5
   AST_STROBE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !fl_ce_n); // R5
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> fl_dq_oe); // R5
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && $past(strobe)) |-> ($stable(fl_addr) && $stable(fl_dout))); // R5
   AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && $past(strobe)) |-> (lo_cnt == 16'(PULSE_CYC))); // R5
   AST_REJECT_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 2'd3) |=> (rsp_valid && rsp_code == 2'd3)); // R4
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready)); // R11
   AST_NO_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready); // R11

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)
) u_chk (.*);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
   localparam int AW  = 17;
   localparam int DW  = 8;
   localparam int NS  = 8;
   localparam int SU  = 1;
   localparam int PW  = 2;
   localparam int HD  = 1;
   localparam int LIM = 6;
   localparam int SSH = AW - 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_ready;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [NS-1:0] req_sect_mask = '0;
   logic          rsp_valid;
   logic [1:0]    rsp_code;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_dout, fl_din;
   logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

   flash_cmd_seq #(
      .ADDR_W(AW), .DATA_W(DW), .NUM_SECT(NS), .SETUP_CYC(SU), .PULSE_CYC(PW),
      .HOLD_CYC(HD), .POLL_LIMIT(LIM), .SECT_GAP_CYC(4000)
   ) i_flash_cmd_seq (.*);

   int n_tests = 0, n_fail = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // flash model: logs writes, counts reads, returns scripted status
   logic [AW-1:0] wlog_a [0:1023];
   logic [7:0]    wlog_d [0:1023];
   int wr_cnt = 0, rd_cnt = 0, rd_bad = 0, pw_bad = 0, lo = 0;
   int rd_base = 0, m_mode = 0, m_b = 0;
   logic [7:0]    m_busy = 8'h00, m_done = 8'hFF;
   logic [AW-1:0] exp_poll = '0;
   logic          prev_we = 1'b1, prev_oe = 1'b1;

   always_comb begin
      int r;
      r = rd_cnt - rd_base;
      case (m_mode)
         0:       fl_din = (r < m_b) ? m_busy : m_done;
         1:       fl_din = (r < m_b) ? m_busy : (m_busy | 8'h20);
         2:       fl_din = (r < m_b) ? m_busy : ((r == m_b) ? (m_busy | 8'h20) : m_done);
         default: fl_din = m_busy;
      endcase
   end

   always @(negedge clk) begin
      if (prev_we && !fl_we_n) begin
         wlog_a[wr_cnt % 1024] = fl_addr;
         wlog_d[wr_cnt % 1024] = fl_dout;
         wr_cnt = wr_cnt + 1;
         if (fl_ce_n || !fl_dq_oe || !fl_oe_n) pw_bad = pw_bad + 1;
      end
      if (!prev_we && fl_we_n && lo != PW) pw_bad = pw_bad + 1;
      if (!prev_oe && fl_oe_n) begin
         rd_cnt = rd_cnt + 1;
         if (fl_addr != exp_poll) rd_bad = rd_bad + 1;
         if (lo != PW || fl_dq_oe) pw_bad = pw_bad + 1;
      end
      if ((!fl_we_n || !fl_oe_n) && fl_ce_n) pw_bad = pw_bad + 1;
      lo      = (!fl_we_n || !fl_oe_n) ? lo + 1 : 0;
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
   end

   logic [AW-1:0] exp_a [0:31];
   logic [7:0]    exp_d [0:31];
   int exp_n;

   task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
      exp_a[exp_n] = a;
      exp_d[exp_n] = d;
      exp_n++;
   endtask

   // mode: 0 busy b reads then done, 1 bit5 at read b and stuck,
   //       2 bit5 at read b then done, 3 never done
   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [7:0] d, input logic [NS-1:0] m,
                         input int mode, input int b, input bit hold);
      bit    ok_req;
      int    code, reads, wr0, rb0, pw0, cyc, busy_bad, bad_w, low;
      string wtag, ctag;
      ok_req = !(op == 2'd3 || (op == 2'd2 && m == '0));
      wtag   = (op == 2'd0) ? "R1" : (op == 2'd1) ? "R2" : "R3";
      exp_n  = 0;
      low    = 0;
      for (int i = NS - 1; i >= 0; i--) if (m[i]) low = i;
      if (ok_req) begin
         push(AW'(17'h5555), 8'hAA);
         push(AW'(17'h2AAA), 8'h55);
         push(AW'(17'h5555), (op == 2'd0) ? 8'hA0 : 8'h80);
         if (op == 2'd0) push(a, d);
         else begin
            push(AW'(17'h5555), 8'hAA);
            push(AW'(17'h2AAA), 8'h55);
            if (op == 2'd1) push(AW'(17'h5555), 8'h10);
            else for (int i = 0; i < NS; i++) if (m[i]) push(AW'(i) << SSH, 8'h30);
         end
      end
      if (!ok_req)            begin code = 3; reads = 0;    ctag = "R4";  end
      else if (mode == 3 || b >= LIM) begin code = 2; reads = LIM; ctag = "R10"; end
      else if (mode == 0)     begin code = 0; reads = b + 1; ctag = (op == 2'd0) ? "R6" : "R7"; end
      else if (mode == 2)     begin code = 0; reads = b + 2; ctag = "R8"; end
      else begin
         code = 1; reads = b + 2; ctag = "R9";
         push(AW'(17'h5555), 8'hAA);
         push(AW'(17'h2AAA), 8'h55);
         push(AW'(17'h5555), 8'hF0);
      end
      m_mode   = mode;
      m_b      = b;
      m_busy   = (op == 2'd0) ? {~d[7], 7'h00} : 8'h00;
      m_done   = (op == 2'd0) ? d : 8'hFF;
      exp_poll = (op == 2'd2) ? (AW'(low) << SSH) : a;
      rd_base  = rd_cnt;
      wr0 = wr_cnt; rb0 = rd_bad; pw0 = pw_bad;

      @(negedge clk);
      req_op = op; req_addr = a; req_data = d; req_sect_mask = m; req_valid = 1'b1;
      chk(req_ready == 1'b1, "R11", "ready while idle", int'(req_ready), 1);
      @(negedge clk);
      if (hold) req_op = 2'd3; else req_valid = 1'b0;
      cyc = 1; busy_bad = 0;
      while (!rsp_valid && cyc < 3000) begin
         if (req_ready) busy_bad++;
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, ctag, "response seen", int'(rsp_valid), 1);
      chk(int'(rsp_code) == code, ctag, "result code", int'(rsp_code), code);
      chk(busy_bad == 0, "R11", "ready low while busy", busy_bad, 0);
      if (!ok_req) chk(cyc == 1, "R4", "reject latency", cyc, 1);
      chk(wr_cnt - wr0 == exp_n, wtag, "write count", wr_cnt - wr0, exp_n);
      bad_w = 0;
      for (int i = 0; i < exp_n && i < wr_cnt - wr0; i++)
         if (wlog_a[(wr0 + i) % 1024] != exp_a[i] || wlog_d[(wr0 + i) % 1024] != exp_d[i])
            bad_w++;
      chk(bad_w == 0, (code == 1) ? "R9" : wtag, "write content mismatches", bad_w, 0);
      chk(rd_cnt - rd_base == reads, ctag, "status reads", rd_cnt - rd_base, reads);
      chk(rd_bad == rb0, (op == 2'd0) ? "R6" : "R7", "poll address errors", rd_bad - rb0, 0);
      chk(pw_bad == pw0, "R5", "strobe shape errors", pw_bad - pw0, 0);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R11", "one-cycle response",
          int'(rsp_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11", "reset handshake",
          int'({req_ready, rsp_valid}), 2);
      chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R5", "reset bus idle",
          int'({fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}), 14);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // program: data patterns x status modes x busy lengths
      for (int dv = 0; dv < 256; dv += 51)
         for (int md = 0; md < 4; md++)
            for (int b = 0; b <= LIM + 1; b++)
               run_op(2'd0, AW'(17'h1_2345 + dv), 8'(dv), '0, md, b, 1'b0);
      // chip erase under each mode
      for (int md = 0; md < 4; md++)
         for (int b = 0; b <= LIM; b += 2)
            run_op(2'd1, AW'(17'h0_0F0F), 8'h00, '0, md, b, 1'b0);
      // sector erase: every mask
      for (int mk = 1; mk < 256; mk++)
         run_op(2'd2, '0, 8'h00, NS'(mk), 0, 1, 1'b0);
      for (int md = 1; md < 4; md++)
         run_op(2'd2, '0, 8'h00, 8'b1010_0100, md, 3, 1'b0);
      // rejects and a request held during busy
      run_op(2'd3, AW'(17'h0_0001), 8'h11, 8'hFF, 0, 0, 1'b0);
      run_op(2'd2, '0, 8'h00, '0, 0, 0, 1'b0);
      run_op(2'd0, AW'(17'h1_0000), 8'h80, '0, 0, 2, 1'b1);
      run_op(2'd1, AW'(17'h0_0004), 8'h00, '0, 1, 1, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 200000 cycles expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule